// File: doc/BRIEF.md
# Channel Command Validation Unit

This block judges every command byte that a channel delivers during initial selection. On the cycle the command-sample strobe is high it decides two things: whether the code names a command the device knows, and whether the device can run that command now, given which optional features are fitted and whether the display buffer is being regenerated. A command that passes is accepted. A command that fails raises unit check in the status byte returned to the channel and records the reasons in sticky sense bits. In both cases the outcome is held until the next strobe.

The Test I/O code has its own path. It is always accepted and never raises unit check. It wipes the sense bits and reports the regeneration-busy condition in the status byte. The block also marks accepted commands that move no data, so that the sequencer outside can go straight to the ending phase. Bus handshaking and the execution of commands are handled elsewhere.

Top module: `cmd_validator`

## Requirements
- R1: After reset, cmd_accept, unit_check and no_data are 0, status_byte is 8'h00 and sense_bits is 3'b000.
- R2: cmd_accept, unit_check, no_data and status_byte change only on a clock edge at which cmd_sample is 1. Each such edge loads the outcome for cmd_byte, feat_present and regen_busy, and the result is visible after that edge.
- R3: The recognised codes are 8'h00 (Test I/O), 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h09, 8'h0A, 8'h0B, 8'h0F and 8'h13. Any other code is an invalid-code cause and sets sense bit 0. An invalid code is judged on that cause alone.
- R4: The codes 8'h02, 8'h05, 8'h06, 8'h0F and 8'h13 need the buffer feature (feat_present[0]). The codes 8'h09 and 8'h0A need the keyboard feature (feat_present[1]). If a needed feature is absent, that is a missing-feature cause and sets sense bit 1.
- R5: The codes 8'h02, 8'h05 and 8'h06, sampled while regen_busy is 1, give a busy-regenerating cause and set sense bit 2. A cause of this kind and a missing-feature cause may both be recorded for one command.
- R6: If any cause is present, unit_check is 1, cmd_accept is 0 and status_byte is 8'h40 (bit 6 is unit check).
- R7: A recognised command with no cause sets cmd_accept to 1 and unit_check to 0. For every code except Test I/O, status_byte is then 8'h00.
- R8: no_data is 1 only for accepted commands with code 8'h00, 8'h03, 8'h0B, 8'h0F or 8'h13. It is 0 for every other accepted code and for every rejected command.
- R9: Sense bits are sticky. New causes are ORed in, and the bits hold until a sense_clr pulse or a Test I/O. When a clear and a reject fall on the same edge, the new causes survive the clear.
- R10: Test I/O (8'h00) is accepted whatever the features and regen_busy. It never raises unit check and it clears all sense bits. Its status_byte is 8'h10 when regen_busy is 1 and 8'h00 otherwise (bit 4 is busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_byte | input | 8 | Command code from the channel |
| cmd_sample | input | 1 | Strobe: judge cmd_byte at this edge |
| feat_present | input | 2 | Fitted optional features: bit 0 buffer, bit 1 keyboard |
| regen_busy | input | 1 | Buffer regeneration in progress |
| sense_clr | input | 1 | Pulse: sense bytes have been read out |
| cmd_accept | output | 1 | Command accepted |
| unit_check | output | 1 | Command rejected |
| no_data | output | 1 | Accepted command needs no data transfer |
| status_byte | output | 8 | Status byte for the selection response |
| sense_bits | output | 3 | Sticky causes: bit 0 invalid, bit 1 feature, bit 2 regenerating |

## Verification
The bench covers these corner cases:
- A command that lacks its feature while regeneration is running must record both causes. A design that reported only the first match would lose sense bit 2.
- A second reject that arrives before any clear must add to the first. A design that overwrote the sense bits would drop the earlier cause.
- A reject that lands on the same edge as sense_clr must survive the clear. A design with the priority the wrong way round would report an empty sense register.
- Test I/O is sampled with regeneration busy and with features missing. A design that routed it through the normal checks would raise unit check or leave stale sense.
- Strobe-free cycles carrying hostile bytes show whether the outcome registers leak between samples.

// File: rtl/cmdval_pkg.sv
package cmdval_pkg;
  localparam int CMD_W   = 8;
  localparam int FEAT_W  = 2;
  localparam int SENSE_W = 3;

  localparam int FEAT_BUF = 0;
  localparam int FEAT_KBD = 1;

  localparam int CAUSE_INVALID = 0;
  localparam int CAUSE_FEATURE = 1;
  localparam int CAUSE_REGEN   = 2;

  typedef struct packed {
    logic              known;
    logic              test_io;
    logic              no_data;
    logic [FEAT_W-1:0] needs;
    logic              regen_blocked;
  } cmd_info_t;

  function automatic cmd_info_t decode_cmd(input logic [CMD_W-1:0] c);
    cmd_info_t r;
    r = '0;
    r.known = 1'b1;
    case (c)
      8'h00: begin r.test_io = 1'b1; r.no_data = 1'b1; end
      8'h01: ;
      8'h02: begin r.needs[FEAT_BUF] = 1'b1; r.regen_blocked = 1'b1; end
      8'h03: r.no_data = 1'b1;
      8'h04: ;
      8'h05: begin r.needs[FEAT_BUF] = 1'b1; r.regen_blocked = 1'b1; end
      8'h06: begin r.needs[FEAT_BUF] = 1'b1; r.regen_blocked = 1'b1; end
      8'h09: r.needs[FEAT_KBD] = 1'b1;
      8'h0A: r.needs[FEAT_KBD] = 1'b1;
      8'h0B: r.no_data = 1'b1;
      8'h0F: begin r.needs[FEAT_BUF] = 1'b1; r.no_data = 1'b1; end
      8'h13: begin r.needs[FEAT_BUF] = 1'b1; r.no_data = 1'b1; end
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] build_status(input logic uc, input logic busy,
                                              input int uc_bit, input int busy_bit);
    logic [7:0] s;
    s = '0;
    s[uc_bit]   = uc;
    s[busy_bit] = busy;
    return s;
  endfunction
endpackage

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import cmdval_pkg::*;
#(
  parameter int W = CMD_W
) (
  input  logic [W-1:0] cmd_byte,
  output cmd_info_t    info
);
  always_comb info = decode_cmd(cmd_byte);
endmodule

// File: rtl/reject_eval.sv
module reject_eval
  import cmdval_pkg::*;
#(
  parameter int NF = FEAT_W,
  parameter int NS = SENSE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_sample,
  input  cmd_info_t     info,
  input  logic [NF-1:0] feat_present,
  input  logic          regen_busy,
  output logic [NS-1:0] causes
);
  logic invalid_w, feat_miss_w, regen_hit_w;

  assign invalid_w   = !info.known;
  assign feat_miss_w = info.known && |(info.needs & ~feat_present);
  assign regen_hit_w = info.known && info.regen_blocked && regen_busy;

  always_comb begin
    causes = '0;
    causes[CAUSE_INVALID] = invalid_w;
    causes[CAUSE_FEATURE] = feat_miss_w;
    causes[CAUSE_REGEN]   = regen_hit_w;
  end

  // R10
  test_io_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sample && info.test_io) |-> (causes == '0));
  // R3
  invalid_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sample && causes[CAUSE_INVALID]) |-> ($countones(causes) == 1));
endmodule

// File: rtl/sense_store.sv
module sense_store
  import cmdval_pkg::*;
#(
  parameter int NS = SENSE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_sample,
  input  logic          sense_clr,
  input  logic          tio_clear,
  input  logic [NS-1:0] causes,
  output logic [NS-1:0] sense_q
);
  logic          wipe_w;
  logic [NS-1:0] kept_w;

  assign wipe_w = sense_clr || (cmd_sample && tio_clear);
  assign kept_w = wipe_w ? '0 : sense_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sense_q <= '0;
    else        sense_q <= kept_w | (cmd_sample ? causes : '0);
  end

  // R9
  sense_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_sample && !sense_clr) |=> $stable(sense_q));
  // R10
  tio_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sample && tio_clear) |=> (sense_q == '0));
endmodule

// File: rtl/cmd_validator.sv
module cmd_validator
  import cmdval_pkg::*;
#(
  parameter int CW       = CMD_W,
  parameter int NF       = FEAT_W,
  parameter int NS       = SENSE_W,
  parameter int UC_BIT   = 6,
  parameter int BUSY_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cmd_byte,
  input  logic          cmd_sample,
  input  logic [NF-1:0] feat_present,
  input  logic          regen_busy,
  input  logic          sense_clr,
  output logic          cmd_accept,
  output logic          unit_check,
  output logic          no_data,
  output logic [7:0]    status_byte,
  output logic [NS-1:0] sense_bits
);
  cmd_info_t     info_w;
  logic [NS-1:0] causes_w;
  logic          reject_w;

  cmd_decoder #(.W(CW)) u_dec (.cmd_byte(cmd_byte), .info(info_w));

  reject_eval #(.NF(NF), .NS(NS)) u_rej (
    .clk(clk), .rst_n(rst_n), .cmd_sample(cmd_sample), .info(info_w),
    .feat_present(feat_present), .regen_busy(regen_busy), .causes(causes_w));

  sense_store #(.NS(NS)) u_sense (
    .clk(clk), .rst_n(rst_n), .cmd_sample(cmd_sample), .sense_clr(sense_clr),
    .tio_clear(info_w.test_io), .causes(causes_w), .sense_q(sense_bits));

  assign reject_w = |causes_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_accept  <= 1'b0;
      unit_check  <= 1'b0;
      no_data     <= 1'b0;
      status_byte <= '0;
    end else if (cmd_sample) begin
      cmd_accept  <= !reject_w;
      unit_check  <= reject_w;
      no_data     <= info_w.no_data && !reject_w;
      status_byte <= build_status(reject_w, info_w.test_io && regen_busy, UC_BIT, BUSY_BIT);
    end
  end

  // R2
  outcome_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_sample |=> $stable({cmd_accept, unit_check, no_data, status_byte}));
  // R6
  reject_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sample && reject_w) |=> (unit_check && !cmd_accept && sense_bits != '0));
  // R8
  no_data_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_data |-> cmd_accept);
  // R10
  tio_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sample && info_w.test_io) |=> (cmd_accept && !unit_check && sense_bits == '0));
endmodule

// File: tb/cmd_validator_test.sv
`timescale 1ns/1ps
module cmd_validator_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       cmd_sample = 1'b0;
  logic [1:0] feat_present = 2'b11;
  logic       regen_busy = 1'b0;
  logic       sense_clr = 1'b0;
  logic       cmd_accept, unit_check, no_data;
  logic [7:0] status_byte;
  logic [2:0] sense_bits;

  int checks = 0;
  int fails  = 0;
  logic [2:0] exp_sense = '0;

  always #2.5 clk = ~clk;

  cmd_validator uut (
    .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .cmd_sample(cmd_sample),
    .feat_present(feat_present), .regen_busy(regen_busy), .sense_clr(sense_clr),
    .cmd_accept(cmd_accept), .unit_check(unit_check), .no_data(no_data),
    .status_byte(status_byte), .sense_bits(sense_bits));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Independent reference: bit0 unknown, bit1 feature missing, bit2 regen block
  function automatic logic [2:0] ref_causes(input logic [7:0] c, input logic [1:0] f, input logic rb);
    logic buf_need, kbd_need, regen_need;
    buf_need   = (c == 8'h02) || (c == 8'h05) || (c == 8'h06) || (c == 8'h0F) || (c == 8'h13);
    kbd_need   = (c == 8'h09) || (c == 8'h0A);
    regen_need = (c == 8'h02) || (c == 8'h05) || (c == 8'h06);
    if (!(c inside {8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h09, 8'h0A, 8'h0B, 8'h0F, 8'h13}))
      return 3'b001;
    return {regen_need && rb, (buf_need && !f[0]) || (kbd_need && !f[1]), 1'b0};
  endfunction

  task automatic issue(input string req, input logic [7:0] c, input logic [1:0] f,
                       input logic rb, input logic clr);
    logic [2:0] cs;
    logic ok;
    logic nd;
    logic [7:0] st;
    cs = ref_causes(c, f, rb);
    ok = (cs == 3'b000);
    nd = ok && (c inside {8'h00, 8'h03, 8'h0B, 8'h0F, 8'h13});
    st = ok ? ((c == 8'h00 && rb) ? 8'h10 : 8'h00) : 8'h40;
    exp_sense = ((clr || c == 8'h00) ? 3'b000 : exp_sense) | cs;
    @(negedge clk);
    cmd_byte = c; feat_present = f; regen_busy = rb; sense_clr = clr; cmd_sample = 1'b1;
    @(negedge clk);
    cmd_sample = 1'b0; sense_clr = 1'b0;
    check({req, " accept"}, 16'(cmd_accept), 16'(ok));
    check({req, " unit_check"}, 16'(unit_check), 16'(!ok));
    check({req, " no_data"}, 16'(no_data), 16'(nd));
    check({req, " status"}, 16'(status_byte), 16'(st));
    check({req, " sense"}, 16'(sense_bits), 16'(exp_sense));
  endtask

  task automatic pulse_clear(input string req);
    @(negedge clk); sense_clr = 1'b1;
    @(negedge clk); sense_clr = 1'b0;
    exp_sense = '0;
    check({req, " sense after clear"}, 16'(sense_bits), 16'h0);
  endtask

  task automatic test_reset();
    check("R1 accept", 16'(cmd_accept), 16'h0);
    check("R1 unit_check", 16'(unit_check), 16'h0);
    check("R1 no_data", 16'(no_data), 16'h0);
    check("R1 status", 16'(status_byte), 16'h00);
    check("R1 sense", 16'(sense_bits), 16'h0);
  endtask

  task automatic test_accepts();
    issue("R7 R8 nop", 8'h03, 2'b11, 1'b0, 1'b0);
    issue("R7 R8 write direct", 8'h01, 2'b11, 1'b0, 1'b0);
    issue("R7 R8 cursor insert", 8'h0F, 2'b11, 1'b0, 1'b0);
    issue("R7 R8 alarm", 8'h0B, 2'b00, 1'b1, 1'b0);
    issue("R7 sense cmd busy", 8'h04, 2'b00, 1'b1, 1'b0);
  endtask

  task automatic test_hold();
    @(negedge clk);
    cmd_byte = 8'hFF; regen_busy = 1'b1; feat_present = 2'b00;
    repeat (3) @(negedge clk);
    check("R2 hold accept", 16'(cmd_accept), 16'h1);
    check("R2 hold status", 16'(status_byte), 16'h00);
    check("R2 hold sense", 16'(sense_bits), 16'(exp_sense));
  endtask

  task automatic test_rejects();
    issue("R3 R6 invalid", 8'h7F, 2'b11, 1'b0, 1'b0);
    pulse_clear("R9");
    issue("R3 invalid with busy", 8'h07, 2'b00, 1'b1, 1'b0);
    pulse_clear("R9");
    issue("R4 no buffer", 8'h02, 2'b10, 1'b0, 1'b0);
    pulse_clear("R9");
    issue("R4 no keyboard", 8'h0A, 2'b01, 1'b0, 1'b0);
    pulse_clear("R9");
    issue("R5 regen busy", 8'h05, 2'b11, 1'b1, 1'b0);
    pulse_clear("R9");
    issue("R5 R4 both causes", 8'h06, 2'b00, 1'b1, 1'b0);
    pulse_clear("R9");
  endtask

  task automatic test_sticky();
    issue("R9 first reject", 8'hC0, 2'b11, 1'b0, 1'b0);
    issue("R9 accumulate", 8'h02, 2'b11, 1'b1, 1'b0);
    issue("R9 accept keeps sense", 8'h01, 2'b11, 1'b0, 1'b0);
    issue("R9 clear with reject", 8'h09, 2'b00, 1'b0, 1'b1);
  endtask

  task automatic test_tio();
    issue("R9 preload", 8'h55, 2'b11, 1'b0, 1'b0);
    issue("R10 tio busy", 8'h00, 2'b00, 1'b1, 1'b0);
    issue("R9 preload again", 8'h05, 2'b11, 1'b1, 1'b0);
    issue("R10 tio idle", 8'h00, 2'b11, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_accepts();
    test_hold();
    test_rejects();
    test_sticky();
    test_tio();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule